// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block sits on the host side of a two-wire serial link to a 32-bit-frame data converter whose chip select is wired permanently low. The host drives the serial clock and the converter drives the data line. There is no separate ready pin. While the converter is busy the data line sits high. It drops low when a result is waiting. The reader finds readiness by watching the data line itself between frames.

After reset the reader holds the serial clock low for a programmable number of system cycles. This covers the converter's power-up window, so the converter comes up expecting an external clock. The reader then polls the synchronized data line. When it reads low, the reader issues exactly 32 clock pulses and captures one bit in each high phase, most significant bit first. It then presents the 24-bit result, the flag bit above it and an error bit, together with a one-cycle valid strobe.

A status bit reports a converter that stays busy too long. In wirings where the converter's select line is routed to the host, a stop request cuts a frame short: the reader raises the select output, which makes the converter drop the read and start a fresh conversion.

Top module: `adc_link_reader`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, `sck_o`, `cs_o`, `valid_o` and `timeout_o` are all 0.
- R2: `sck_o` stays low for at least `POR_CYC` clock cycles after reset is released, whatever the level of `sdo_i`.
- R3: While `sdo_i` stays high in the polling state, no clock pulse is produced.
- R4: Once the synchronized `sdo_i` reads 0 during polling, exactly 32 pulses follow on `sck_o`, starting with a rising edge. Each pulse is high for `HALF_PER` cycles and then low for `HALF_PER` cycles.
- R5: One bit is captured in each high phase, first bit as frame bit 31 down to bit 0. `result_o` equals frame bits 27 down to 4 (bit 27 as the MSB) and `flag_o` equals frame bit 28.
- R6: `valid_o` is high for exactly one cycle, at the end of the low phase that follows the 32nd falling edge. `result_o`, `flag_o` and `err_o` keep their values until the next `valid_o`.
- R7: `err_o` equals frame bit 31 of the last completed frame. It is 1 when the end-of-conversion bit was read as 1.
- R8: If the converter stays busy for `TIMEOUT_CYC` consecutive polling cycles, `timeout_o` is set. It is cleared on the next rising edge of `sck_o` that begins a frame.
- R9: A stop request (`stop_req_i` high for a clock) during a frame forces `sck_o` low and raises `cs_o` for exactly 2*`HALF_PER` cycles. No further pulses or `valid_o` come from that frame, and polling resumes afterwards.
- R10: `stop_req_i` is ignored outside a frame: `cs_o` stays 0, no clock pulse appears and the held outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdo_i | input | 1 | Serial data from the converter (asynchronous) |
| stop_req_i | input | 1 | Request to abandon the current frame |
| sck_o | output | 1 | Serial clock to the converter |
| cs_o | output | 1 | Select line to the converter; high only to abort a read |
| result_o | output | DATA_W | 24-bit conversion result of the last frame |
| flag_o | output | 1 | Frame bit 28 of the last frame |
| err_o | output | 1 | End-of-conversion bit of the last frame was read as 1 |
| valid_o | output | 1 | One-cycle strobe: new result available |
| timeout_o | output | 1 | Converter stayed busy past the timeout limit |

## Verification
A wrong phase counter shows directly as high or low phases of the wrong length on `sck_o`, within the first pulse of a frame. A wrong bit counter shows as a pulse count other than 32 and a missing or early `valid_o` at the end of that frame. Broken field steering shows as a wrong `result_o`, `flag_o` or `err_o` on the first completed frame. A lost timeout or abort path shows at `timeout_o` or `cs_o` within `TIMEOUT_CYC` or 2*`HALF_PER` cycles of the trigger.

// File: rtl/adc_rd_pkg.sv
// Shared definitions for the two-wire converter reader.
// Assumes nothing beyond a synthesizable enum encoding.
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_POR,    // power-up hold, clock kept low
        ST_POLL,   // watching the data line for end of conversion
        ST_HI,     // clock high phase, capture at its end
        ST_LO,     // clock low phase
        ST_ABORT   // select raised to drop the read
    } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
// Multi-stage synchronizer for a single asynchronous input.
// Assumes STAGES >= 2; reset value is the idle level of the line.
module adc_rd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_frame.sv
// Frame capture: counts captured bits and steers each bit into the field
// it belongs to by its position, MSB first. Fields are copied to the
// held outputs on commit, with a one-cycle valid.
// Assumes sample_i pulses at most FRAME_BITS times between clear_i.
module adc_rd_frame #(
    parameter int FRAME_BITS = 32,
    parameter int DATA_W     = 24,
    parameter int DATA_LSB   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              flag_o,
    output logic              err_o,
    output logic              valid_o
);
    localparam int CNT_W    = $clog2(FRAME_BITS + 1);
    localparam int DATA_MSB = DATA_LSB + DATA_W - 1;
    localparam int FLAG_POS = DATA_MSB + 1;
    localparam int ERR_POS  = FRAME_BITS - 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;
    logic              err_q;
    int                pos;

    // Position in the frame of the bit being captured now.
    always_comb pos = ERR_POS - int'(cnt_q);

    assign full_o = (cnt_q == CNT_W'(FRAME_BITS));

    // Count captured bits and steer each one into its field.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q  <= '0;
            data_q <= '0;
            flag_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (sample_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (pos == ERR_POS)  err_q  <= bit_i;
            if (pos == FLAG_POS) flag_q <= bit_i;
            if (pos <= DATA_MSB && pos >= DATA_LSB)
                data_q <= {data_q[DATA_W-2:0], bit_i};
        end
    end

    // Publish the fields of a completed frame and strobe valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            flag_o  <= 1'b0;
            err_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= commit_i;
            if (commit_i) begin
                data_o <= data_q;
                flag_o <= flag_q;
                err_o  <= err_q;
            end
        end
    end

    // R4: the controller never asks for more bits than a frame holds.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |-> !full_o);
    // R6: a frame is committed only when all of its bits are in.
    a_r6_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> full_o);
endmodule

// File: rtl/adc_link_reader.sv
// Host-side reader for a converter with its select tied low: holds the
// clock low through the converter's power-up, polls the data line for
// end of conversion, clocks out a 32-bit frame and publishes the result.
// Assumes HALF_PER >= 3 so the synchronized data settles within a phase.
module adc_link_reader #(
    parameter int HALF_PER    = 4,
    parameter int POR_CYC     = 100000,
    parameter int TIMEOUT_CYC = 40000000,
    parameter int FRAME_BITS  = 32,
    parameter int DATA_W      = 24,
    parameter int DATA_LSB    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdo_i,
    input  logic              stop_req_i,
    output logic              sck_o,
    output logic              cs_o,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_o,
    output logic              err_o,
    output logic              valid_o,
    output logic              timeout_o
);
    import adc_rd_pkg::*;

    localparam int LONG_MAX  = (POR_CYC > TIMEOUT_CYC) ? POR_CYC : TIMEOUT_CYC;
    localparam int TICK_MAX  = (LONG_MAX > 2 * HALF_PER) ? LONG_MAX : 2 * HALF_PER;
    localparam int TW        = $clog2(TICK_MAX + 1);

    rd_state_e     state_q;
    logic [TW-1:0] tick_q;
    logic          sdo_s;
    logic          in_frame;
    logic          phase_end;
    logic          sample;
    logic          start;
    logic          commit;
    logic          frame_full;

    adc_rd_sync #(.STAGES(2), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sdo_i),
        .q_o   (sdo_s)
    );

    // Decode the strobes the frame capture needs.
    always_comb begin
        in_frame  = (state_q == ST_HI) || (state_q == ST_LO);
        phase_end = (tick_q == TW'(HALF_PER - 1));
        start     = (state_q == ST_POLL) && !sdo_s;
        sample    = (state_q == ST_HI) && phase_end && !stop_req_i;
        commit    = (state_q == ST_LO) && phase_end && !stop_req_i && frame_full;
    end

    adc_rd_frame #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_W     (DATA_W),
        .DATA_LSB   (DATA_LSB)
    ) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .sample_i (sample),
        .bit_i    (sdo_s),
        .commit_i (commit),
        .full_o   (frame_full),
        .data_o   (result_o),
        .flag_o   (flag_o),
        .err_o    (err_o),
        .valid_o  (valid_o)
    );

    // Sequence power-up hold, polling, clock phases and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_POR;
            tick_q    <= '0;
            sck_o     <= 1'b0;
            cs_o      <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_POR: begin
                    if (tick_q == TW'(POR_CYC - 1)) begin
                        state_q <= ST_POLL;
                        tick_q  <= '0;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (!sdo_s) begin
                        state_q   <= ST_HI;
                        sck_o     <= 1'b1;
                        tick_q    <= '0;
                        timeout_o <= 1'b0;
                    end else if (tick_q == TW'(TIMEOUT_CYC - 1)) begin
                        timeout_o <= 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                ST_HI, ST_LO: begin
                    if (stop_req_i) begin
                        state_q <= ST_ABORT;
                        sck_o   <= 1'b0;
                        cs_o    <= 1'b1;
                        tick_q  <= '0;
                    end else if (!phase_end) begin
                        tick_q <= tick_q + 1'b1;
                    end else if (state_q == ST_HI) begin
                        state_q <= ST_LO;
                        sck_o   <= 1'b0;
                        tick_q  <= '0;
                    end else if (frame_full) begin
                        state_q <= ST_POLL;
                        tick_q  <= '0;
                    end else begin
                        state_q <= ST_HI;
                        sck_o   <= 1'b1;
                        tick_q  <= '0;
                    end
                end
                ST_ABORT: begin
                    if (tick_q == TW'(2 * HALF_PER - 1)) begin
                        state_q <= ST_POLL;
                        cs_o    <= 1'b0;
                        tick_q  <= '0;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: state_q <= ST_POLL;
            endcase
        end
    end

    // Cycles since reset, saturating at POR_CYC; used only by the checks.
    logic [TW-1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                since_rst_q <= '0;
        else if (since_rst_q != TW'(POR_CYC))      since_rst_q <= since_rst_q + 1'b1;
    end

    // R2: no clock pulse inside the power-up window.
    a_r2_por_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < TW'(POR_CYC)) |-> !sck_o);
    // R4: a rising clock edge is held high for the next cycle too.
    a_r4_sck_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |=> sck_o);
    // R6: valid is a single-cycle strobe, issued with the clock low.
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r6_valid_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!sck_o && !cs_o));
    // R9: select and clock are never high together.
    a_r9_cs_sck_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> !sck_o);
    // R10: a stop request outside a frame leaves select low.
    a_r10_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_i && !in_frame && !cs_o) |=> !cs_o);
    // R8: the busy flag only stands while no clock is running.
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !sck_o);
endmodule

// File: tb/adc_link_reader_tb_top.sv
// Directed bench for adc_link_reader with a behavioural converter model.
module adc_link_reader_tb_top;
    localparam int HALF_PER    = 4;
    localparam int POR_CYC     = 50;
    localparam int TIMEOUT_CYC = 200;
    localparam int DATA_W      = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sdo = 1'b0;
    logic              stop_req = 1'b0;
    logic              sck_o, cs_o, flag_o, err_o, valid_o, timeout_o;
    logic [DATA_W-1:0] result_o;

    int checks_n = 0;
    int errors_n = 0;
    int rise_cnt = 0;
    int hi_cycles = 0;
    int cs_cycles = 0;

    // converter model state
    logic [31:0] word = 32'h1234_5670;
    int          idx = 31;
    bit          shifting = 1'b1;

    always #2.5 clk = ~clk;

    adc_link_reader #(
        .HALF_PER (HALF_PER), .POR_CYC (POR_CYC), .TIMEOUT_CYC (TIMEOUT_CYC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sdo_i (sdo), .stop_req_i (stop_req),
        .sck_o (sck_o), .cs_o (cs_o), .result_o (result_o), .flag_o (flag_o),
        .err_o (err_o), .valid_o (valid_o), .timeout_o (timeout_o)
    );

    // Observers of the link.
    always @(posedge sck_o) rise_cnt++;
    always @(posedge clk) begin
        if (sck_o) hi_cycles++;
        if (cs_o)  cs_cycles++;
    end

    // Converter: next bit on each falling clock edge, high after the last.
    always @(negedge sck_o) begin
        #1;
        if (shifting && !cs_o) begin
            idx--;
            if (idx >= 0) sdo = word[idx];
            else begin sdo = 1'b1; shifting = 1'b0; end
        end
    end
    // Converter: select high drops the read and starts a conversion.
    always @(posedge cs_o) begin
        #1;
        shifting = 1'b0;
        sdo = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks_n++;
        if (!ok) begin
            errors_n++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_word(input logic [31:0] w);
        word = w; idx = 31; shifting = 1'b1; sdo = w[31];
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            @(posedge clk); #1;
            if (valid_o) got = 1'b1;
        end
    endtask

    task automatic check_frame(input string tag, input logic [31:0] w, input int r0, input int h0);
        bit got;
        wait_valid(got);
        chk(got, tag, "valid seen", 32'(got), 1);
        chk(result_o == w[27:4], "R5", "result", 32'(result_o), 32'(w[27:4]));
        chk(flag_o == w[28], "R5", "flag", 32'(flag_o), 32'(w[28]));
        chk(err_o == w[31], "R7", "err", 32'(err_o), 32'(w[31]));
        chk(rise_cnt - r0 == 32, "R4", "pulse count", 32'(rise_cnt - r0), 32);
        chk(hi_cycles - h0 == 32 * HALF_PER, "R4", "high cycles", 32'(hi_cycles - h0), 32'(32 * HALF_PER));
        cycles(1);
        chk(!valid_o, "R6", "valid one cycle", 32'(valid_o), 0);
    endtask

    // R1, R2, R4, R5: reset state, power-up hold, first frame.
    task automatic t_reset_por();
        int r0, h0, n;
        cycles(3);
        chk(!sck_o && !cs_o && !valid_o && !timeout_o, "R1", "reset outputs",
            {28'b0, sck_o, cs_o, valid_o, timeout_o}, 0);
        r0 = rise_cnt; h0 = hi_cycles;
        @(posedge clk); #1 rst_n = 1'b1;
        chk(!sck_o && !cs_o && !valid_o && !timeout_o, "R1", "after release",
            {28'b0, sck_o, cs_o, valid_o, timeout_o}, 0);
        n = 0;
        while (rise_cnt == r0 && n < 500) begin @(posedge clk); #1; n++; end
        chk(n >= POR_CYC, "R2", "cycles before first pulse", 32'(n), 32'(POR_CYC));
        check_frame("R6", 32'h1234_5670, r0, h0);
    endtask

    // R3, R6: busy converter produces no pulses; outputs held; next frame.
    task automatic t_busy_then_frame();
        int r0, h0;
        logic [DATA_W-1:0] held;
        held = result_o;
        r0 = rise_cnt;
        cycles(100);
        chk(rise_cnt == r0, "R3", "no pulses while busy", 32'(rise_cnt - r0), 0);
        chk(!timeout_o, "R8", "no early timeout", 32'(timeout_o), 0);
        chk(result_o == held, "R6", "result held", 32'(result_o), 32'(held));
        h0 = hi_cycles;
        load_word(32'h0FED_CBA9);
        check_frame("R6", 32'h0FED_CBA9, r0, h0);
    endtask

    // R7: end-of-conversion bit read as 1 is reported.
    task automatic t_error_bit();
        int r0, h0;
        r0 = rise_cnt; h0 = hi_cycles;
        shifting = 1'b0; sdo = 1'b0;
        @(posedge sck_o); #1;
        load_word(32'h9000_0AB0);
        check_frame("R7", 32'h9000_0AB0, r0, h0);
    endtask

    // R8: long busy period raises the status bit, a frame clears it.
    task automatic t_timeout();
        int r0, h0;
        r0 = rise_cnt;
        cycles(TIMEOUT_CYC + 20);
        chk(timeout_o, "R8", "timeout set", 32'(timeout_o), 1);
        chk(rise_cnt == r0, "R3", "no pulses during timeout", 32'(rise_cnt - r0), 0);
        h0 = hi_cycles;
        load_word(32'h0AAA_5550);
        @(posedge sck_o); cycles(1);
        chk(!timeout_o, "R8", "timeout cleared", 32'(timeout_o), 0);
        check_frame("R6", 32'h0AAA_5550, r0, h0);
    endtask

    // R9: stop request mid-frame aborts with a timed select pulse.
    task automatic t_abort();
        int r0, c0, h0;
        bit saw_valid;
        r0 = rise_cnt; c0 = cs_cycles;
        load_word(32'h0555_AAA0);
        wait (rise_cnt == r0 + 10);
        @(posedge clk); #1 stop_req = 1'b1;
        @(posedge clk); #1 stop_req = 1'b0;
        saw_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (valid_o) saw_valid = 1'b1;
        end
        chk(!saw_valid, "R9", "no valid after abort", 32'(saw_valid), 0);
        chk(rise_cnt == r0 + 10, "R9", "pulses stop", 32'(rise_cnt - r0), 10);
        chk(cs_cycles - c0 == 2 * HALF_PER, "R9", "select high cycles",
            32'(cs_cycles - c0), 32'(2 * HALF_PER));
        chk(!cs_o, "R9", "select back low", 32'(cs_o), 0);
        r0 = rise_cnt; h0 = hi_cycles;
        load_word(32'h1357_9BD0);
        check_frame("R9", 32'h1357_9BD0, r0, h0);
    endtask

    // R10: stop request while polling changes nothing.
    task automatic t_stop_idle();
        int r0, c0;
        logic [DATA_W-1:0] held;
        held = result_o; r0 = rise_cnt; c0 = cs_cycles;
        cycles(5);
        stop_req = 1'b1; cycles(1); stop_req = 1'b0;
        cycles(20);
        chk(cs_cycles == c0, "R10", "select stays low", 32'(cs_cycles - c0), 0);
        chk(rise_cnt == r0, "R10", "no pulses", 32'(rise_cnt - r0), 0);
        chk(result_o == held, "R10", "result unchanged", 32'(result_o), 32'(held));
    endtask

    initial begin
        t_reset_por();
        t_busy_then_frame();
        t_error_bit();
        t_timeout();
        t_abort();
        t_stop_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks_n, errors_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks_n++; errors_n++;
        $display("FAIL watchdog: run did not complete, actual timeout expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks_n, errors_n);
        $finish;
    end
endmodule